// File: doc/BRIEF.md
# Peripheral clock gate and reset sequencer

This block controls the clock gate, the reset lanes and an integer clock divider for one peripheral, all inside the parent clock domain. Software-visible state lives in four word registers reached through a plain write/read port. One register holds the per-lane gate bits, one holds the per-lane reset bits, and one holds a divider word in which only a parameterised bit field carries the divide value. A fourth write-only location accepts a requested output rate and turns it into a divide value.

Two request inputs start fixed two-step sequences. An enable request opens the masked gate bits first and releases the masked reset bits one cycle later. A disable request asserts the masked reset bits first and closes the masked gate bits one cycle later. While any sequence or rate conversion is running, the block reports busy and ignores new requests and register writes.

The divided output is a single-cycle enable strobe at the parent clock rate divided by the field value. It is forced low while every masked gate bit is clear, and it is fanned out per lane through that lane's gate bit.

Top module: `periph_clkrst_ctrl`

## Requirements
- R1: After reset the reset register reads all ones, the gate register and the divider register read zero, `busy`, `enabled` and `div_strobe` are low, and every `lane_rst` bit is high.
- R2: Addresses 0x0 (reset register), 0x4 (divider word) and 0x8 (gate register) store the full `wdata` word on a write accepted while idle and return it on `rdata` with no delay; address 0xC reads zero.
- R3: An enable request accepted while idle raises `busy` at the next edge. The edge after that sets the `CLK_MASK` bits of the gate register, and the following edge clears the `RST_MASK` bits of the reset register and drops `busy`. Bits outside the masks are unchanged.
- R4: A disable request accepted while idle raises `busy` at the next edge. The edge after that sets the `RST_MASK` bits of the reset register, and the following edge clears the `CLK_MASK` bits of the gate register and drops `busy`.
- R5: `enabled` is high exactly when the gate register ANDed with `CLK_MASK` is non-zero.
- R6: While `busy` is high, `en_req`, `dis_req` and register writes have no effect. When both requests arrive together while idle, the enable sequence runs.
- R7: The divide value is bits [DIV_SHIFT+DIV_WIDTH-1:DIV_SHIFT] of the divider word. While enabled, `div_strobe` fires once every divide-value cycles. A value of zero, or DIV_WIDTH of zero, divides by one.
- R8: A write to the divider word restarts the count. The first strobe is visible in the divide-value-th cycle, counting the cycle right after the write edge as cycle 1.
- R9: `div_strobe` and all of `lane_ce` stay low while `enabled` is low. `lane_ce[i]` equals `div_strobe` AND gate register bit i.
- R10: A write of a non-zero rate r to address 0xC raises `busy` for a bounded number of cycles. It then replaces only the divide field with floor(PARENT_RATE / min(r, PARENT_RATE)), saturated to the field maximum. A rate of zero, or DIV_WIDTH of zero, leaves the divider word and `busy` unchanged.
- R11: `lane_rst[i]` equals bit i of the reset register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| en_req | input | 1 | Start the enable sequence |
| dis_req | input | 1 | Start the disable sequence |
| busy | output | 1 | A sequence or rate conversion is in progress |
| enabled | output | 1 | Some masked gate bit is set |
| div_strobe | output | 1 | Divided single-cycle clock-enable strobe |
| lane_ce | output | LANES | Per-lane gated strobe |
| lane_rst | output | LANES | Per-lane reset, active high |

## Verification
The main instance uses both masks at 0x6, so lane 0 stays outside every sequence and lanes 1 and 2 show the ordering, while lane 3 keeps its reset bit. The same instance places a 6-bit divide field at bit 8 with a parent rate of 100. Set bits on both sides of the field then show that extraction and the rate write ignore their neighbours, and a requested rate of 1 reaches the saturation limit of 63. A second instance built with a divide width of zero shows the divide-by-one fallback and a rate write that has no effect.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

  // Sequencer states: two steps for each direction.
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_EN_GATE,
    SEQ_EN_REL,
    SEQ_DIS_HOLD,
    SEQ_DIS_GATE
  } seq_state_e;

  // One-hot step commands issued by the sequencer to the register file.
  typedef struct packed {
    logic set_gate;
    logic clr_rst;
    logic set_rst;
    logic clr_gate;
  } seq_step_t;

endpackage

// File: rtl/pcr_rst_sync.sv
module pcr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  // Asserts at once, releases after STAGES edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/pcr_seq.sv
module pcr_seq
  import pcr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_req,
  input  logic      dis_req,
  input  logic      hold,
  output seq_step_t step,
  output logic      seq_busy
);

  seq_state_e state_q;
  seq_state_e state_d;

  always_comb begin
    state_d = state_q;
    step    = '0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (!hold) begin
          if (en_req) begin
            state_d = SEQ_EN_GATE;
          end else if (dis_req) begin
            state_d = SEQ_DIS_HOLD;
          end
        end
      end
      SEQ_EN_GATE: begin
        step.set_gate = 1'b1;
        state_d       = SEQ_EN_REL;
      end
      SEQ_EN_REL: begin
        step.clr_rst = 1'b1;
        state_d      = SEQ_IDLE;
      end
      SEQ_DIS_HOLD: begin
        step.set_rst = 1'b1;
        state_d      = SEQ_DIS_GATE;
      end
      SEQ_DIS_GATE: begin
        step.clr_gate = 1'b1;
        state_d       = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign seq_busy = (state_q != SEQ_IDLE);

endmodule

// File: rtl/pcr_rate_calc.sv
module pcr_rate_calc #(
  parameter int                DATA_W      = 32,
  parameter int                FIELD_W     = 8,
  parameter logic [DATA_W-1:0] PARENT_RATE = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DATA_W-1:0]  rate,
  output logic               done,
  output logic               calc_busy,
  output logic [FIELD_W-1:0] quotient
);

  localparam int                CNT_W     = $clog2(DATA_W + 1);
  localparam logic [DATA_W-1:0] FIELD_MAX = DATA_W'((64'd1 << FIELD_W) - 64'd1);

  logic              run_q, run_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] dvd_q, dvd_d;
  logic [DATA_W-1:0] dvs_q, dvs_d;
  logic [DATA_W-1:0] rem_q, rem_d;
  logic [DATA_W-1:0] quo_q, quo_d;
  logic [DATA_W:0]   rem_sh;
  logic [DATA_W:0]   rem_sub;
  logic              step_en;

  assign rem_sh  = {rem_q, dvd_q[DATA_W-1]};
  assign rem_sub = rem_sh - {1'b0, dvs_q};
  assign step_en = start | run_q;

  // Restoring division: one quotient bit per cycle.
  always_comb begin
    run_d  = run_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    dvd_d  = dvd_q;
    dvs_d  = dvs_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    if (start) begin
      run_d = 1'b1;
      cnt_d = CNT_W'(DATA_W);
      dvd_d = PARENT_RATE;
      dvs_d = (rate > PARENT_RATE) ? PARENT_RATE : rate;
      rem_d = '0;
      quo_d = '0;
    end else if (run_q) begin
      dvd_d = dvd_q << 1;
      if (rem_sh >= {1'b0, dvs_q}) begin
        rem_d = rem_sub[DATA_W-1:0];
        quo_d = {quo_q[DATA_W-2:0], 1'b1};
      end else begin
        rem_d = rem_sh[DATA_W-1:0];
        quo_d = {quo_q[DATA_W-2:0], 1'b0};
      end
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dvd_q <= '0;
      dvs_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
    end else if (step_en) begin
      cnt_q <= cnt_d;
      dvd_q <= dvd_d;
      dvs_q <= dvs_d;
      rem_q <= rem_d;
      quo_q <= quo_d;
    end
  end

  assign done      = done_q;
  assign calc_busy = run_q | done_q;
  assign quotient  = (quo_q > FIELD_MAX) ? FIELD_MAX[FIELD_W-1:0] : quo_q[FIELD_W-1:0];

endmodule

// File: rtl/pcr_strobe.sv
module pcr_strobe #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_on,
  input  logic          restart,
  input  logic [FW-1:0] div_fld,
  output logic          strobe
);

  logic [FW-1:0] cnt_q, cnt_d;
  logic [FW-1:0] last;

  // A zero field behaves as divide by one.
  assign last = (div_fld == '0) ? '0 : div_fld - FW'(1);

  always_comb begin
    if (!gate_on || restart) begin
      cnt_d = '0;
    end else if (cnt_q >= last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + FW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign strobe = gate_on && (cnt_q >= last);

endmodule

// File: rtl/periph_clkrst_ctrl.sv
module periph_clkrst_ctrl
  import pcr_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                ADDR_W      = 4,
  parameter int                LANES       = 4,
  parameter logic [DATA_W-1:0] CLK_MASK    = 'hF,
  parameter logic [DATA_W-1:0] RST_MASK    = 'hF,
  parameter int                RST_ADDR    = 0,
  parameter int                DIV_ADDR    = 4,
  parameter int                CLK_ADDR    = 8,
  parameter int                RATE_ADDR   = 12,
  parameter int                DIV_SHIFT   = 0,
  parameter int                DIV_WIDTH   = 8,
  parameter logic [DATA_W-1:0] PARENT_RATE = 1000,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              en_req,
  input  logic              dis_req,
  output logic              busy,
  output logic              enabled,
  output logic              div_strobe,
  output logic [LANES-1:0]  lane_ce,
  output logic [LANES-1:0]  lane_rst
);

  localparam int                FW        = (DIV_WIDTH > 0) ? DIV_WIDTH : 1;
  localparam logic [ADDR_W-1:0] A_RST     = ADDR_W'(RST_ADDR);
  localparam logic [ADDR_W-1:0] A_DIV     = ADDR_W'(DIV_ADDR);
  localparam logic [ADDR_W-1:0] A_CLK     = ADDR_W'(CLK_ADDR);
  localparam logic [ADDR_W-1:0] A_RATE    = ADDR_W'(RATE_ADDR);
  localparam logic [DATA_W-1:0] FLD_MASK  = DATA_W'((64'd1 << DIV_WIDTH) - 64'd1);
  localparam logic [DATA_W-1:0] FLD_PLACE = FLD_MASK << DIV_SHIFT;

  logic              rst_sn;
  seq_step_t         step;
  logic              seq_busy;
  logic              calc_busy;
  logic              calc_done;
  logic [FW-1:0]     calc_quo;
  logic              calc_start;
  logic [FW-1:0]     div_fld;
  logic              acc_wr;
  logic              div_restart;

  logic [DATA_W-1:0] gate_q, gate_d;
  logic [DATA_W-1:0] rstr_q, rstr_d;
  logic [DATA_W-1:0] divr_q, divr_d;
  logic              gate_ld, rstr_ld, divr_ld;

  // Reset: asynchronous assertion, synchronous release.
  pcr_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sn)
  );

  pcr_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_sn),
    .en_req   (en_req),
    .dis_req  (dis_req),
    .hold     (calc_busy),
    .step     (step),
    .seq_busy (seq_busy)
  );

  assign busy   = seq_busy | calc_busy;
  assign acc_wr = wr_en & ~busy;

  // Divide field and rate conversion exist only when the field has width.
  generate
    if (DIV_WIDTH > 0) begin : g_div_field
      assign div_fld    = FW'(divr_q >> DIV_SHIFT);
      assign calc_start = acc_wr && (addr == A_RATE) && (wdata != '0);

      pcr_rate_calc #(
        .DATA_W      (DATA_W),
        .FIELD_W     (FW),
        .PARENT_RATE (PARENT_RATE)
      ) u_rate_calc (
        .clk       (clk),
        .rst_n     (rst_sn),
        .start     (calc_start),
        .rate      (wdata),
        .done      (calc_done),
        .calc_busy (calc_busy),
        .quotient  (calc_quo)
      );
    end else begin : g_no_div_field
      assign div_fld    = '0;
      assign calc_start = 1'b0;
      assign calc_done  = 1'b0;
      assign calc_busy  = 1'b0;
      assign calc_quo   = '0;
    end
  endgenerate

  // Register next state; sequence steps only occur while writes are blocked.
  always_comb begin
    gate_d  = gate_q;
    rstr_d  = rstr_q;
    divr_d  = divr_q;
    gate_ld = 1'b0;
    rstr_ld = 1'b0;
    divr_ld = 1'b0;
    if (acc_wr && (addr == A_CLK)) begin
      gate_d  = wdata;
      gate_ld = 1'b1;
    end
    if (acc_wr && (addr == A_RST)) begin
      rstr_d  = wdata;
      rstr_ld = 1'b1;
    end
    if (acc_wr && (addr == A_DIV)) begin
      divr_d  = wdata;
      divr_ld = 1'b1;
    end
    if (step.set_gate) begin
      gate_d  = gate_q | CLK_MASK;
      gate_ld = 1'b1;
    end
    if (step.clr_gate) begin
      gate_d  = gate_q & ~CLK_MASK;
      gate_ld = 1'b1;
    end
    if (step.set_rst) begin
      rstr_d  = rstr_q | RST_MASK;
      rstr_ld = 1'b1;
    end
    if (step.clr_rst) begin
      rstr_d  = rstr_q & ~RST_MASK;
      rstr_ld = 1'b1;
    end
    if (calc_done) begin
      divr_d  = (divr_q & ~FLD_PLACE) | (DATA_W'(calc_quo) << DIV_SHIFT);
      divr_ld = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      gate_q <= '0;
    end else if (gate_ld) begin
      gate_q <= gate_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rstr_q <= '1;
    end else if (rstr_ld) begin
      rstr_q <= rstr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      divr_q <= '0;
    end else if (divr_ld) begin
      divr_q <= divr_d;
    end
  end

  assign enabled     = |(gate_q & CLK_MASK);
  assign div_restart = (acc_wr && (addr == A_DIV)) || calc_done;

  pcr_strobe #(
    .FW (FW)
  ) u_strobe (
    .clk     (clk),
    .rst_n   (rst_sn),
    .gate_on (enabled),
    .restart (div_restart),
    .div_fld (div_fld),
    .strobe  (div_strobe)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_ce[g]  = div_strobe & gate_q[g];
      assign lane_rst[g] = rstr_q[g];
    end
  endgenerate

  always_comb begin
    if (addr == A_RST) begin
      rdata = rstr_q;
    end else if (addr == A_DIV) begin
      rdata = divr_q;
    end else if (addr == A_CLK) begin
      rdata = gate_q;
    end else begin
      rdata = '0;
    end
  end

endmodule

// File: rtl/pcr_checker.sv
module pcr_checker #(
  parameter int                DATA_W    = 32,
  parameter int                LANES     = 4,
  parameter logic [DATA_W-1:0] CLK_MASK  = 'hF,
  parameter logic [DATA_W-1:0] RST_MASK  = 'hF,
  parameter int                DIV_SHIFT = 0,
  parameter int                DIV_WIDTH = 8
) (
  input logic              clk,
  input logic              srst_n,
  input logic              busy,
  input logic              enabled,
  input logic              div_strobe,
  input logic [LANES-1:0]  lane_ce,
  input logic [DATA_W-1:0] gate_q,
  input logic [DATA_W-1:0] rstr_q,
  input logic [DATA_W-1:0] divr_q
);

  localparam logic [DATA_W-1:0] FMASK = DATA_W'((64'd1 << DIV_WIDTH) - 64'd1);

  logic [DATA_W-1:0] fld_now;
  assign fld_now = (divr_q >> DIV_SHIFT) & FMASK;

  // R3: masked reset bits are released only once the masked gate bits are all open.
  assert_gate_open_before_release_R3: assert property (
    @(posedge clk) disable iff (!srst_n)
    ($past(busy) && (($past(rstr_q) & RST_MASK) != '0) && ((rstr_q & RST_MASK) == '0))
      |-> ((gate_q & CLK_MASK) == CLK_MASK)
  );

  // R4: masked gate bits close only while the masked reset bits are all asserted.
  assert_reset_before_gate_close_R4: assert property (
    @(posedge clk) disable iff (!srst_n)
    ($past(busy) && (($past(gate_q) & CLK_MASK) != '0) && ((gate_q & CLK_MASK) == '0))
      |-> ((rstr_q & RST_MASK) == RST_MASK)
  );

  // R7: with a divide value of two or more, strobes never come back to back.
  assert_strobe_spacing_R7: assert property (
    @(posedge clk) disable iff (!srst_n)
    (div_strobe && (fld_now >= DATA_W'(2))) |=> (!div_strobe || !$stable(divr_q))
  );

  // R9: nothing toggles while the gate is closed.
  assert_no_strobe_when_gated_R9: assert property (
    @(posedge clk) disable iff (!srst_n)
    !enabled |-> (!div_strobe && (lane_ce == '0))
  );

endmodule

bind periph_clkrst_ctrl pcr_checker #(
  .DATA_W    (DATA_W),
  .LANES     (LANES),
  .CLK_MASK  (CLK_MASK),
  .RST_MASK  (RST_MASK),
  .DIV_SHIFT (DIV_SHIFT),
  .DIV_WIDTH (DIV_WIDTH)
) u_pcr_checker (
  .clk        (clk),
  .srst_n     (rst_sn),
  .busy       (busy),
  .enabled    (enabled),
  .div_strobe (div_strobe),
  .lane_ce    (lane_ce),
  .gate_q     (gate_q),
  .rstr_q     (rstr_q),
  .divr_q     (divr_q)
);

// File: tb/test_periph_clkrst_ctrl.sv
module test_periph_clkrst_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_RST  = 4'h0;
  localparam logic [AW-1:0] A_DIV  = 4'h4;
  localparam logic [AW-1:0] A_CLK  = 4'h8;
  localparam logic [AW-1:0] A_RATE = 4'hC;

  logic clk = 1'b0;
  logic rst_n;

  // main instance
  logic          wr_en, en_req, dis_req;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          busy, enabled, div_strobe;
  logic [3:0]    lane_ce, lane_rst;

  // divide-width-zero instance
  logic          n_wr_en, n_en_req;
  logic [AW-1:0] n_addr;
  logic [DW-1:0] n_wdata, n_rdata;
  logic          n_busy, n_enabled, n_strobe;
  logic [3:0]    n_lane_ce, n_lane_rst;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  int  exp_q[$];
  logic [3:0] exp_lanes;
  int  gap;
  bit  armed = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_clkrst_ctrl #(
    .CLK_MASK    (32'h6),
    .RST_MASK    (32'h6),
    .DIV_SHIFT   (8),
    .DIV_WIDTH   (6),
    .PARENT_RATE (32'd100)
  ) i_periph_clkrst_ctrl (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr), .wdata (wdata),
    .rdata (rdata), .en_req (en_req), .dis_req (dis_req), .busy (busy),
    .enabled (enabled), .div_strobe (div_strobe), .lane_ce (lane_ce), .lane_rst (lane_rst)
  );

  periph_clkrst_ctrl #(
    .DIV_WIDTH   (0),
    .PARENT_RATE (32'd100)
  ) i_periph_clkrst_ctrl_nodiv (
    .clk (clk), .rst_n (rst_n), .wr_en (n_wr_en), .addr (n_addr), .wdata (n_wdata),
    .rdata (n_rdata), .en_req (n_en_req), .dis_req (1'b0), .busy (n_busy),
    .enabled (n_enabled), .div_strobe (n_strobe), .lane_ce (n_lane_ce), .lane_rst (n_lane_rst)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  // scoreboard driver: queue expected strobe gaps, then write the divider word
  task automatic div_case(input logic [DW-1:0] word, input int period, input int count);
    for (int i = 0; i < count; i++) exp_q.push_back(period);
    wr(A_DIV, word);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // scoreboard monitor: a quarter period after each edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (wr_en && addr == A_DIV && !busy) begin
      gap   = 1;
      armed = 1'b1;
    end else begin
      gap++;
    end
    if (div_strobe) begin
      if (armed && exp_q.size() > 0) begin
        chk("R7/R8 strobe gap", DW'(gap), DW'(exp_q.pop_front()));
        chk("R9 lane_ce pattern", DW'(lane_ce), DW'(exp_lanes));
        if (exp_q.size() == 0) armed = 1'b0;
      end
      gap = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; en_req = 1'b0; dis_req = 1'b0; addr = '0; wdata = '0;
    n_wr_en = 1'b0; n_en_req = 1'b0; n_addr = '0; n_wdata = '0;
    exp_lanes = 4'b0110;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk("R1 lane_rst", DW'(lane_rst), 32'hF);
    chk("R1 busy/enabled/strobe", DW'({busy, enabled, div_strobe}), 32'h0);
    rd_chk("R1 reset reg", A_RST, 32'hFFFFFFFF);
    rd_chk("R1 gate reg", A_CLK, 32'h0);
    rd_chk("R1 divider reg", A_DIV, 32'h0);

    // register map and lane reset fan-out
    wr(A_RST, 32'hA5A5A5A5);
    rd_chk("R2 reset reg readback", A_RST, 32'hA5A5A5A5);
    chk("R11 lane_rst follows register", DW'(lane_rst), 32'h5);
    rd_chk("R2 rate address reads zero", A_RATE, 32'h0);
    wr(A_RST, 32'hFFFFFFFF);
    chk("R11 lane_rst all set", DW'(lane_rst), 32'hF);

    // enable sequence, order observed step by step
    @(negedge clk); addr = A_CLK; en_req = 1'b1;
    @(negedge clk); en_req = 1'b0;
    chk("R3 busy after request", DW'(busy), 32'h1);
    chk("R3 gate not yet open", rdata, 32'h0);
    @(negedge clk);
    chk("R3 gate opened first", rdata, 32'h6);
    chk("R3 reset still held", DW'(lane_rst), 32'hF);
    chk("R5 enabled once gate open", DW'(enabled), 32'h1);
    @(negedge clk);
    chk("R3 masked reset released", DW'(lane_rst), 32'h9);
    chk("R3 busy dropped", DW'(busy), 32'h0);

    // strobe divider via scoreboard, field bits 13:8 with set neighbours
    div_case(32'hFFFFC3FF, 3, 4);
    rd_chk("R2 divider readback", A_DIV, 32'hFFFFC3FF);
    div_case(32'hFFFFC0FF, 1, 4);
    div_case(32'h00000500, 5, 3);
    div_case(32'h00000200, 2, 3);

    // disable sequence with ignored request and write while busy
    @(negedge clk); addr = A_CLK; dis_req = 1'b1;
    @(negedge clk); dis_req = 1'b0; en_req = 1'b1; wr_en = 1'b1; wdata = 32'hFFFFFFFF;
    @(negedge clk); en_req = 1'b0; wr_en = 1'b0;
    chk("R4 reset asserted first", DW'(lane_rst), 32'hF);
    chk("R4 gate still open", rdata, 32'h6);
    chk("R6 write during busy ignored", rdata, 32'h6);
    @(negedge clk);
    chk("R4 gate closed", rdata, 32'h0);
    chk("R5 enabled low", DW'(enabled), 32'h0);
    @(negedge clk);
    chk("R6 request during busy ignored", DW'(busy), 32'h0);
    chk("R6 gate stays closed", rdata, 32'h0);

    // gated: no strobe for a divide-by-one setting
    wr(A_DIV, 32'h0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R9 no strobe while gated", DW'({div_strobe, lane_ce}), 32'h0);
    end

    // both requests together: enable wins
    @(negedge clk); en_req = 1'b1; dis_req = 1'b1;
    @(negedge clk); en_req = 1'b0; dis_req = 1'b0;
    @(negedge clk); addr = A_CLK; #1;
    chk("R6 simultaneous requests pick enable", rdata, 32'h6);
    wait_idle();
    chk("R6 reset released after enable", DW'(lane_rst), 32'h9);

    // rate conversion
    wr(A_DIV, 32'hFFFFC0FF);
    wr(A_RATE, 32'd7);
    chk("R10 busy during conversion", DW'(busy), 32'h1);
    wait_idle();
    rd_chk("R10 rate 7 gives 14, neighbours kept", A_DIV, 32'hFFFFCEFF);
    wr(A_RATE, 32'd250);
    wait_idle();
    rd_chk("R10 rate above parent clamps to 1", A_DIV, 32'hFFFFC1FF);
    wr(A_RATE, 32'd1);
    wait_idle();
    rd_chk("R10 quotient saturates to 63", A_DIV, 32'hFFFFFFFF);
    wr(A_RATE, 32'd0);
    chk("R10 zero rate leaves busy low", DW'(busy), 32'h0);
    rd_chk("R10 zero rate leaves divider", A_DIV, 32'hFFFFFFFF);

    // divide width zero instance
    @(negedge clk); n_en_req = 1'b1;
    @(negedge clk); n_en_req = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk); n_wr_en = 1'b1; n_addr = A_DIV; n_wdata = 32'h5;
    @(negedge clk); n_wr_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R7 width zero divides by one", DW'(n_strobe), 32'h1);
    end
    @(negedge clk); n_wr_en = 1'b1; n_addr = A_RATE; n_wdata = 32'd3;
    @(negedge clk); n_wr_en = 1'b0;
    chk("R10 width zero rate write no busy", DW'(n_busy), 32'h0);
    n_addr = A_DIV; #1;
    chk("R10 width zero divider unchanged", n_rdata, 32'h5);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule